// File: doc/BRIEF.md
# Single-Register Control Slave on a Two-Wire Serial Bus

This block lets a host on a standard I2C bus program the control byte of a television sound decoder and read back what the decoder has detected. The slave has one 8-bit control register that can only be written. It has no sub-address, so a write transaction carries exactly one data byte. A read transaction returns one status byte. That byte holds the stereo-detected and dual-language-detected flags from the demodulator in its two top bits, with zeros below them.

The SCL and SDA pads are open-drain. The block samples them with a system clock at least 16 times faster than SCL. Each line passes through a two-flop synchronizer, and the block looks for edges after synchronization. The block recognises START and STOP conditions and compares the incoming 7-bit address with a fixed value. It answers with an acknowledge, shifts bytes MSB first, and drives SDA through a pull-low enable. Three cases are discarded and leave the register as it was: a byte cut short by STOP, a transaction to another address, and any byte after the first in a transaction.

Top module: `mts_i2c_ctrl_slave`

## Requirements
- R1: START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a byte (repeated START). STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: Bits are sampled on the rising edge of SCL, most significant bit first. `sda_drive_low_o` changes only after a falling edge of SCL, a START or a STOP.
- R3: The slave acknowledges the 7-bit address 7'b1000000 (byte 0x80 for a write, 0x81 for a read) by pulling SDA low during the 9th clock. It does not acknowledge any other address and ignores the rest of that transaction.
- R4: In a write (bit 0 of the address byte = 0), the slave loads the following byte into `ctrl_byte_o` once its 8th bit has been sampled, and acknowledges it in the 9th clock.
- R5: If STOP arrives before all 8 data bits of the write byte have been received, `ctrl_byte_o` keeps its previous value.
- R6: In a read (bit 0 of the address byte = 1), the slave returns one byte: bit 7 is `stereo_flag_i`, bit 6 is `dual_lang_flag_i`, and bits 5 to 0 are 0. `sda_drive_low_o` is 1 exactly while a 0 bit is on the line.
- R7: After its single data byte the slave stops taking part until the next START. In a read, SDA stays released during the master's acknowledge slot and during any later clocks. In a write, later bytes are not acknowledged and do not change `ctrl_byte_o`.
- R8: After reset, `ctrl_byte_o` is 0x00 and `sda_drive_low_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_pad_i | input | 1 | Level seen on the SCL pad |
| sda_pad_i | input | 1 | Level seen on the SDA pad (wired-AND of all drivers) |
| stereo_flag_i | input | 1 | Stereo-detected flag from the demodulator |
| dual_lang_flag_i | input | 1 | Dual-language-detected flag from the demodulator |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| ctrl_byte_o | output | 8 | Contents of the control register |

## Verification
The bench cuts a write byte short with STOP after five bits, and issues a repeated START in the middle of a data byte. A slave that committed partial bytes or did not restart on START would leave the wrong control value behind. It sends foreign addresses (0x42, and 0x00 as a general call) and extra bytes after the single data byte. A loose address compare, or a missing ignore state, would show up as an acknowledge or a register overwrite. Reads are run with all four flag combinations, followed by an additional byte read. A slave that put the flags in swapped positions, or kept driving after its byte, would return wrong bits or hold the line below 0xFF. The bench writes 0x35, whose bit-reversed value differs, so a design that shifted LSB first would store the wrong value.

// File: rtl/mts_i2c_pkg.sv
package mts_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_SET,
    ST_AACK_END,
    ST_WDATA,
    ST_WACK_SET,
    ST_WACK_END,
    ST_RDATA,
    ST_RREL,
    ST_RMACK,
    ST_IGNORE
  } slave_state_e;

endpackage

// File: rtl/mts_i2c_sync_bit.sv
module mts_i2c_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_lvl,
  output logic q_prev
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_async};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_lvl  = chain_q[STAGES-1];
  assign q_prev = prev_q;

endmodule

// File: rtl/mts_i2c_linecond.sv
module mts_i2c_linecond (
  input  logic scl_lvl,
  input  logic scl_prev,
  input  logic sda_lvl,
  input  logic sda_prev,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_steady_hi;

  always_comb begin
    scl_steady_hi = scl_lvl & scl_prev;
    scl_rise      = scl_lvl & ~scl_prev;
    scl_fall      = ~scl_lvl & scl_prev;
    start_det     = scl_steady_hi & sda_prev & ~sda_lvl;
    stop_det      = scl_steady_hi & ~sda_prev & sda_lvl;
  end

endmodule

// File: rtl/mts_i2c_fsm.sv
module mts_i2c_fsm
  import mts_i2c_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'b1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic              stereo_i,
  input  logic              dual_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] ctl_o
);

  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  slave_state_e      state_q, state_d;
  logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [DATA_W-2:0] shift_q, shift_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] status_byte;
  logic              rw_q, rw_d;
  logic              sda_pull_q, sda_pull_d;
  logic              ctl_en;

  assign status_byte = {stereo_i, dual_i, {(DATA_W-2){1'b0}}};
  assign rx_byte     = {shift_q, sda_lvl};

  always_comb begin
    state_d    = state_q;
    bit_cnt_d  = bit_cnt_q;
    shift_d    = shift_q;
    tx_d       = tx_q;
    rw_d       = rw_q;
    sda_pull_d = sda_pull_q;
    ctl_en     = 1'b0;
    if (stop_det) begin
      state_d    = ST_IDLE;
      sda_pull_d = 1'b0;
    end else if (start_det) begin
      state_d    = ST_ADDR;
      bit_cnt_d  = '0;
      sda_pull_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          shift_d   = rx_byte[DATA_W-2:0];
          bit_cnt_d = bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST) begin
            bit_cnt_d = '0;
            rw_d      = sda_lvl;
            state_d   = (shift_q == DEV_ADDR) ? ST_AACK_SET : ST_IGNORE;
          end
        end
        ST_AACK_SET: if (scl_fall) begin
          sda_pull_d = 1'b1;
          state_d    = ST_AACK_END;
        end
        ST_AACK_END: if (scl_fall) begin
          bit_cnt_d = '0;
          if (rw_q) begin
            tx_d       = status_byte;
            sda_pull_d = ~status_byte[DATA_W-1];
            state_d    = ST_RDATA;
          end else begin
            sda_pull_d = 1'b0;
            state_d    = ST_WDATA;
          end
        end
        ST_WDATA: if (scl_rise) begin
          shift_d   = rx_byte[DATA_W-2:0];
          bit_cnt_d = bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST) begin
            bit_cnt_d = '0;
            ctl_en    = 1'b1;
            state_d   = ST_WACK_SET;
          end
        end
        ST_WACK_SET: if (scl_fall) begin
          sda_pull_d = 1'b1;
          state_d    = ST_WACK_END;
        end
        ST_WACK_END: if (scl_fall) begin
          sda_pull_d = 1'b0;
          state_d    = ST_IGNORE;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt_d = bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST) begin
              bit_cnt_d = '0;
              state_d   = ST_RREL;
            end
          end else if (scl_fall) begin
            tx_d       = tx_q << 1;
            sda_pull_d = ~tx_q[DATA_W-2];
          end
        end
        ST_RREL: if (scl_fall) begin
          sda_pull_d = 1'b0;
          state_d    = ST_RMACK;
        end
        ST_RMACK: if (scl_rise) begin
          state_d = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      sda_pull_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= bit_cnt_d;
      shift_q    <= shift_d;
      tx_q       <= tx_d;
      rw_q       <= rw_d;
      sda_pull_q <= sda_pull_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= rx_byte;
    end
  end

  assign sda_pull_o = sda_pull_q;
  assign ctl_o      = ctl_q;

  // R1: a START always lands in address reception
  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR));

  // R1: a STOP always ends in idle with the line released
  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !sda_pull_q));

  // R2: the SDA drive moves only after SCL falls or a bus condition
  assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_q) |-> $past(scl_fall || start_det || stop_det));

  // R4, R5: the control register moves only on the last data bit of a write
  assert_ctl_full_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_q) |-> $past(state_q == ST_WDATA && scl_rise && bit_cnt_q == LAST
                              && !start_det && !stop_det));

  // R3: a foreign address leads to the ignore state
  assert_foreign_addr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_rise && !start_det && !stop_det && bit_cnt_q == LAST
     && shift_q != DEV_ADDR) |=> (state_q == ST_IGNORE));

  // R6: the first read bit on the line is the stereo flag
  assert_read_msb_stereo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK_END && scl_fall && rw_q && !start_det && !stop_det)
    |=> (sda_pull_q == !$past(stereo_i)));

endmodule

// File: rtl/mts_i2c_ctrl_slave.sv
module mts_i2c_ctrl_slave #(
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_pad_i,
  input  logic              sda_pad_i,
  input  logic              stereo_flag_i,
  input  logic              dual_lang_flag_i,
  output logic              sda_drive_low_o,
  output logic [DATA_W-1:0] ctrl_byte_o
);

  localparam int LINES = 2;
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [LINES-1:0]      pad_w, lvl_w, prev_w;
  logic                  scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  assign pad_w = {sda_pad_i, scl_pad_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    mts_i2c_sync_bit #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
    ) u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .d_async (pad_w[g]),
      .q_lvl   (lvl_w[g]),
      .q_prev  (prev_w[g])
    );
  end

  mts_i2c_linecond u_cond (
    .scl_lvl   (lvl_w[0]),
    .scl_prev  (prev_w[0]),
    .sda_lvl   (lvl_w[1]),
    .sda_prev  (prev_w[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  mts_i2c_fsm #(
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_lvl    (lvl_w[1]),
    .stereo_i   (stereo_flag_i),
    .dual_i     (dual_lang_flag_i),
    .sda_pull_o (sda_drive_low_o),
    .ctl_o      (ctrl_byte_o)
  );

endmodule

// File: tb/mts_i2c_ctrl_slave_test.sv
`timescale 1ns/1ps
module mts_i2c_ctrl_slave_test;

  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       st_flag, dl_flag;
  logic       sda_drive_low;
  logic [7:0] ctrl_byte;
  logic       sda_bus;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_drive_low;

  mts_i2c_ctrl_slave uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .scl_pad_i        (m_scl),
    .sda_pad_i        (sda_bus),
    .stereo_flag_i    (st_flag),
    .dual_lang_flag_i (dl_flag),
    .sda_drive_low_o  (sda_drive_low),
    .ctrl_byte_o      (ctrl_byte)
  );

  typedef struct {
    logic [7:0] v;
    string      req;
    string      what;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] obs_v;
  event       obs_ev;

  task automatic expect_val(input logic [7:0] v, input string req, input string what);
    exp_t e;
    e.v = v; e.req = req; e.what = what;
    exp_q.push_back(e);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_v = v;
    ->obs_ev;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(obs_ev);
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected observation actual=%02h expected=none", obs_v);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (obs_v !== e.v) begin
          failures++;
          $display("FAIL %s %s actual=%02h expected=%02h", e.req, e.what, obs_v, e.v);
        end
      end
    end
  end

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick();
    m_scl = 1'b1; tick();
    m_sda = 1'b0; tick();
    m_scl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick();
    m_scl = 1'b1; tick();
    m_sda = 1'b1; tick();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick();
    m_scl = 1'b1; tick();
    s = sda_bus; tick();
    m_scl = 1'b0; tick();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] r);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      r[i] = s;
    end
    clk_bit(m_ack, s);
  endtask

  task automatic full_write(input logic [7:0] d, input string req);
    logic a;
    bus_start();
    write_byte(8'h80, a);
    expect_val(8'h00, "R3", "address ack on write"); observe({7'b0, a});
    write_byte(d, a);
    expect_val(8'h00, "R4", "data ack"); observe({7'b0, a});
    bus_stop();
    tick();
    expect_val(d, req, "control byte after write"); observe(ctrl_byte);
  endtask

  task automatic full_read(input logic st, input logic dl, input logic m_ack);
    logic       a;
    logic [7:0] r;
    st_flag = st; dl_flag = dl;
    bus_start();
    write_byte(8'h81, a);
    expect_val(8'h00, "R3", "address ack on read"); observe({7'b0, a});
    read_byte(m_ack, r);
    expect_val({st, dl, 6'b0}, "R6", "status byte"); observe(r);
    read_byte(1'b1, r);
    expect_val(8'hFF, "R7", "line released after status byte"); observe(r);
    bus_stop();
    tick();
    expect_val(8'h00, "R1", "drive released after stop"); observe({7'b0, sda_drive_low});
  endtask

  initial begin
    logic a, s;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; st_flag = 1'b0; dl_flag = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    expect_val(8'h00, "R8", "control byte after reset"); observe(ctrl_byte);
    expect_val(8'h00, "R8", "drive after reset"); observe({7'b0, sda_drive_low});

    // R2: 0x35 reversed is 0xAC, so MSB-first order is visible
    full_write(8'h35, "R2");
    full_write(8'hA3, "R4");

    // R3: foreign addresses are not acknowledged and change nothing
    bus_start();
    write_byte(8'h42, a);
    expect_val(8'h01, "R3", "no ack for foreign address"); observe({7'b0, a});
    write_byte(8'h00, a);
    expect_val(8'h01, "R3", "no ack for byte after foreign address"); observe({7'b0, a});
    bus_stop();
    bus_start();
    write_byte(8'h00, a);
    expect_val(8'h01, "R3", "no ack for general call"); observe({7'b0, a});
    bus_stop();
    tick();
    expect_val(8'hA3, "R3", "control byte after foreign address"); observe(ctrl_byte);

    // R5: STOP after five data bits keeps the old value
    bus_start();
    write_byte(8'h80, a);
    expect_val(8'h00, "R3", "address ack before partial byte"); observe({7'b0, a});
    for (int i = 0; i < 5; i++) clk_bit(i[0], s);
    bus_stop();
    tick();
    expect_val(8'hA3, "R5", "control byte after partial byte"); observe(ctrl_byte);

    // R1: repeated START in the middle of a data byte
    bus_start();
    write_byte(8'h80, a);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_start();
    write_byte(8'h80, a);
    expect_val(8'h00, "R1", "address ack after repeated start"); observe({7'b0, a});
    write_byte(8'h6E, a);
    expect_val(8'h00, "R1", "data ack after repeated start"); observe({7'b0, a});
    bus_stop();
    tick();
    expect_val(8'h6E, "R1", "control byte after repeated start"); observe(ctrl_byte);

    // R7: only the first data byte of a write counts
    bus_start();
    write_byte(8'h80, a);
    write_byte(8'h11, a);
    expect_val(8'h00, "R4", "first data byte ack"); observe({7'b0, a});
    write_byte(8'h22, a);
    expect_val(8'h01, "R7", "no ack for second data byte"); observe({7'b0, a});
    bus_stop();
    tick();
    expect_val(8'h11, "R7", "control byte keeps first data byte"); observe(ctrl_byte);

    // R6: all flag combinations, with master NACK and ACK
    full_read(1'b1, 1'b0, 1'b1);
    full_read(1'b0, 1'b1, 1'b1);
    full_read(1'b1, 1'b1, 1'b0);
    full_read(1'b0, 1'b0, 1'b0);

    expect_val(8'h11, "R6", "reads leave control byte"); observe(ctrl_byte);

    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule